// File: doc/BRIEF.md
# Piecewise-Linear Interpolating Sine NCO

This block is a numerically controlled oscillator that emits signed sine samples. A wrapping phase accumulator steps by a runtime tuning word. A runtime phase offset is added to the accumulated phase before conversion. The phase-to-amplitude stage uses quarter-wave symmetry. It folds the second and fourth quadrants onto the first by complementing the low phase bits. It approximates the first quadrant with eight straight-line segments.

Only the nine segment end-points are stored, in a small single-port ROM. The slope of a segment is not stored. It is formed from two consecutive ROM reads that are time-shared over a two-cycle slot. The first read, the segment start, waits in a one-cycle hold register until the second read, the segment end, returns. The interpolation step is then start + ((end - start) * frac) >> FRAC_W. FRAC_W is the width of the within-segment offset, so dividing by the segment length is a right shift.

Each sample takes a two-clock slot, so the sample rate is half the clock rate. The output frequency is tune_word / 2^PHASE_W times the sample rate. With the defaults (PHASE_W = 16, OUT_W = 16), 0x4000 is 90 degrees and the peak code is 32767.

Top module: `nco_pwl_sine`

## Requirements
- R1: While rst is high, and on the first cycle after it falls, sample_valid_o is 0. While rst is high, sample_o is 0.
- R2: After rst is released, sample_valid_o first rises after the 4th rising clock edge. From then on it is high for exactly one cycle out of every two.
- R3: The k-th valid sample after reset (k = 0, 1, ...) converts the phase (phase_offset + k * tune_word) mod 2^PHASE_W. The phase wraps silently, so tune_word = all ones steps the phase backwards by one.
- R4: phase_offset is read as an unsigned phase modulo 2^PHASE_W. A two's-complement negative offset, such as 0xE000 for -45 degrees, shifts the origin backwards.
- R5: The two phase MSBs select the quadrant. Phases with MSB = 0 give a sample >= 0. Phases with MSB = 1 give a sample <= 0.
- R6: Quadrant folding is exact at the axis points. With the defaults, phase 0x0000 and phase 0x8000 give 0, phase 0x4000 gives +32766 and phase 0xC000 gives -32766.
- R7: Every valid sample is within 200 codes of round(32767 * sin(2*pi*phase / 2^PHASE_W)) for the phase defined in R3.
- R8: The sample is saturated to +/-(2^(OUT_W-1) - 1). The most negative code -2^(OUT_W-1) never appears.
- R9: sample_o changes only on the cycle in which sample_valid_o is high. With tune_word = 0 every valid sample has the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | PHASE_W | Phase step added once per sample slot |
| phase_offset | input | PHASE_W | Phase added after the accumulator |
| sample_o | output | OUT_W | Signed sine sample |
| sample_valid_o | output | 1 | High for one cycle when sample_o is new |

## Verification
The bound checker watches four things on every cycle:
- the one-in-two cadence of the valid strobe;
- that the sample does not move between strobes;
- that the most negative code is absent;
- that the sample sign agrees with the quadrant captured for it.

Only the bench's scenarios can show the rest:
- the numeric accuracy against a real-valued sine;
- the accumulator stepping and wrapping, including a zero tuning word and the all-ones word;
- origin shifts from negative phase offsets;
- the exact fold results at the axis points;
- the fill latency after reset.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Eight straight-line segments per quarter wave.
    localparam int SEG_BITS = 3;
    localparam int ROM_AW   = SEG_BITS + 1;
    localparam int ROM_DEPTH = 1 << ROM_AW;

    typedef enum logic {
        SLOT_START = 1'b0,
        SLOT_END   = 1'b1
    } slot_e;

    typedef struct packed {
        logic [1:0]          quad;
        logic [SEG_BITS-1:0] seg;
    } seg_sel_t;

    // Knot amplitudes sin(k*pi/16) in 16-bit unsigned full scale.
    // Indices at and beyond the last knot read full scale.
    function automatic logic [15:0] knot_q16(input logic [ROM_AW-1:0] k);
        logic [15:0] v;
        case (k)
            4'd0:    v = 16'd0;
            4'd1:    v = 16'd12785;
            4'd2:    v = 16'd25079;
            4'd3:    v = 16'd36409;
            4'd4:    v = 16'd46340;
            4'd5:    v = 16'd54490;
            4'd6:    v = 16'd60546;
            4'd7:    v = 16'd64276;
            default: v = 16'd65535;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/nco_phase_path.sv
module nco_phase_path
    import nco_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv,
    input  logic [PHASE_W-1:0]         tune,
    input  logic [PHASE_W-1:0]         offs,
    output seg_sel_t                   sel,
    output logic [PHASE_W-3-SEG_BITS:0] frac
);
    localparam int FOLD_W = PHASE_W - 2;
    localparam int FRAC_W = FOLD_W - SEG_BITS;

    logic [PHASE_W-1:0] acc;
    logic [PHASE_W-1:0] phase;
    logic [1:0]         quad;
    logic [FOLD_W-1:0]  rest;
    logic [FOLD_W-1:0]  folded;

    always_comb begin
        phase  = acc + offs;
        quad   = phase[PHASE_W-1 -: 2];
        rest   = phase[FOLD_W-1:0];
        // Quadrants 2 and 4 run backwards: complement the in-quadrant phase.
        folded = quad[0] ? ~rest : rest;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            sel  <= '0;
            frac <= '0;
        end else if (adv) begin
            acc      <= acc + tune;
            sel.quad <= quad;
            sel.seg  <= folded[FOLD_W-1 -: SEG_BITS];
            frac     <= folded[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/nco_seg_rom.sv
module nco_seg_rom
    import nco_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROM_AW-1:0] addr,
    output logic [OUT_W-2:0]  data
);
    localparam int AMP_W = OUT_W - 1;
    localparam int RSH   = 17 - OUT_W;

    logic [AMP_W-1:0] mem [ROM_DEPTH];

    for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_knot
        assign mem[k] = AMP_W'(knot_q16(ROM_AW'(k)) >> RSH);
    end

    // Single registered read port: one access per clock.
    always_ff @(posedge clk) begin
        if (rst) data <= '0;
        else     data <= mem[addr];
    end

endmodule

// File: rtl/nco_interp.sv
module nco_interp #(
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic [OUT_W-2:0]        start_q,
    input  logic [OUT_W-2:0]        end_q,
    input  logic [FRAC_W-1:0]       frac,
    input  logic                    neg,
    output logic signed [OUT_W-1:0] sample,
    output logic                    valid
);
    localparam int AMP_W = OUT_W - 1;
    localparam int W     = AMP_W + FRAC_W + 3;
    localparam int MAXV  = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [W-1:0] MAX_W = W'(MAXV);

    logic signed [W-1:0] q0_w, q1_w, fr_w, slope_w, prod_w, step_w, mag_w, res_w, sat_w;

    always_comb begin
        q0_w    = $signed({{(W-AMP_W){1'b0}}, start_q});
        q1_w    = $signed({{(W-AMP_W){1'b0}}, end_q});
        fr_w    = $signed({{(W-FRAC_W){1'b0}}, frac});
        slope_w = q1_w - q0_w;
        prod_w  = slope_w * fr_w;
        step_w  = prod_w >>> FRAC_W;
        mag_w   = q0_w + step_w;
        res_w   = neg ? -mag_w : mag_w;
        if (res_w > MAX_W)       sat_w = MAX_W;
        else if (res_w < -MAX_W) sat_w = -MAX_W;
        else                     sat_w = res_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= fire;
            if (fire) sample <= sat_w[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/nco_pwl_sine.sv
module nco_pwl_sine
    import nco_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PHASE_W-1:0]      tune_word,
    input  logic [PHASE_W-1:0]      phase_offset,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    sample_valid_o
);
    localparam int FRAC_W = PHASE_W - 2 - SEG_BITS;

    slot_e              slot;
    logic [1:0]         fill;
    seg_sel_t           sel;
    logic [FRAC_W-1:0]  frac;
    logic [ROM_AW-1:0]  rom_addr;
    logic [OUT_W-2:0]   rom_q;
    logic [OUT_W-2:0]   hold_q;
    logic [FRAC_W-1:0]  s2_frac;
    logic               s2_neg;
    logic               fire;

    // Two-cycle slot: START edge captures a phase, END edge finishes a sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_START;
            fill <= '0;
        end else begin
            slot <= (slot == SLOT_START) ? SLOT_END : SLOT_START;
            if (!(&fill)) fill <= fill + 2'd1;
        end
    end

    nco_phase_path #(.PHASE_W(PHASE_W)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .adv  (slot == SLOT_START),
        .tune (tune_word),
        .offs (phase_offset),
        .sel  (sel),
        .frac (frac)
    );

    // END edge reads the segment start; START edge reads the segment end.
    assign rom_addr = {1'b0, sel.seg} + ROM_AW'(slot == SLOT_START);

    nco_seg_rom #(.OUT_W(OUT_W)) u_rom (
        .clk  (clk),
        .rst  (rst),
        .addr (rom_addr),
        .data (rom_q)
    );

    // One-cycle delay of the start knot plus the sample's side data.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            s2_frac <= '0;
            s2_neg  <= 1'b0;
        end else if (slot == SLOT_START) begin
            hold_q  <= rom_q;
            s2_frac <= frac;
            s2_neg  <= sel.quad[1];
        end
    end

    assign fire = (slot == SLOT_END) && (&fill);

    nco_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_interp (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .start_q (hold_q),
        .end_q   (rom_q),
        .frac    (s2_frac),
        .neg     (s2_neg),
        .sample  (sample_o),
        .valid   (sample_valid_o)
    );

endmodule

module nco_pwl_sine_chk #(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    valid,
    input logic signed [OUT_W-1:0] sample,
    input logic                    neg
);
    localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid);

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R2
    valid_cadence_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(valid) |=> valid);

    // R5
    quadrant_sign_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (neg ? (sample <= 0) : (sample >= 0)));

    // R8
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sample != MIN_CODE));

    // R9
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(sample));

endmodule

bind nco_pwl_sine nco_pwl_sine_chk #(.OUT_W(OUT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .valid  (sample_valid_o),
    .sample (sample_o),
    .neg    (s2_neg)
);

// File: tb/nco_pwl_sine_tb.sv
module nco_pwl_sine_tb;

    localparam int PW  = 16;
    localparam int OW  = 16;
    localparam int TOL = 200;
    localparam int NS  = 16;
    localparam real TWO_PI = 6.283185307179586;

    typedef struct packed {
        logic [PW-1:0] tw;
        logic [PW-1:0] off;
    } vec_t;

    // Stimulus: tuning word and phase offset; expected samples follow R3/R7.
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h2000},   // zero step, +45 deg
        '{16'h0000, 16'hE000},   // zero step, -45 deg (R4)
        '{16'h0123, 16'h0000},
        '{16'h0FFF, 16'h4000},
        '{16'hFFFF, 16'h0000},   // maximum word: steps backwards (R3)
        '{16'h8000, 16'h1000},
        '{16'h0400, 16'hC000},   // -90 deg origin (R4)
        '{16'h1357, 16'hF000}    // -22.5 deg origin (R4)
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [PW-1:0]        tune_word = '0;
    logic [PW-1:0]        phase_offset = '0;
    logic signed [OW-1:0] sample_o;
    logic                 sample_valid_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nco_pwl_sine #(.PHASE_W(PW), .OUT_W(OW)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .tune_word      (tune_word),
        .phase_offset   (phase_offset),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic [PW-1:0] tw, input logic [PW-1:0] off);
        @(negedge clk);
        rst          = 1'b1;
        tune_word    = tw;
        phase_offset = off;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic next_sample(output int s);
        do @(negedge clk); while (!sample_valid_o);
        s = int'(sample_o);
    endtask

    function automatic int ideal(input int p);
        return int'($rtoi(32767.0 * $sin(TWO_PI * real'(p) / 65536.0) + 32768.5)) - 32768;
    endfunction

    initial begin
        int s, first, p, e, d;

        // R1: reset state, checked while rst is still high
        @(negedge clk);
        @(negedge clk);
        check(sample_valid_o == 1'b0, "R1 valid in reset", int'(sample_valid_o), 0);
        check(sample_o == 0, "R1 sample in reset", int'(sample_o), 0);

        // R2: fill latency and cadence
        restart(16'h0000, 16'h2000);
        for (int c = 1; c <= 9; c++) begin
            @(negedge clk);
            check(sample_valid_o == ((c >= 4) && (c % 2 == 0)), "R2 valid cadence",
                  int'(sample_valid_o), int'((c >= 4) && (c % 2 == 0)));
        end

        // Table walk: R3, R4, R5, R7, R8
        for (int v = 0; v < NV; v++) begin
            restart(VECS[v].tw, VECS[v].off);
            for (int k = 0; k < NS; k++) begin
                next_sample(s);
                p = (int'(VECS[v].off) + k * int'(VECS[v].tw)) & 16'hFFFF;
                e = ideal(p);
                d = s - e;
                check(d <= TOL && d >= -TOL, "R7 accuracy (R3 phase, R4 origin)", s, e);
                check(p[15] ? (s <= 0) : (s >= 0), "R5 quadrant sign", s, e);
                check(s != -32768, "R8 saturation", s, -32767);
            end
        end

        // R6: exact axis points
        restart(16'h0000, 16'h0000); next_sample(s);
        check(s == 0, "R6 phase 0", s, 0);
        restart(16'h0000, 16'h4000); next_sample(s);
        check(s == 32766, "R6 phase 90", s, 32766);
        restart(16'h0000, 16'h8000); next_sample(s);
        check(s == 0, "R6 phase 180", s, 0);
        restart(16'h0000, 16'hC000); next_sample(s);
        check(s == -32766, "R6 phase 270", s, -32766);

        // R9: zero tuning word holds the sample constant
        restart(16'h0000, 16'h3456);
        next_sample(first);
        for (int k = 0; k < 4; k++) begin
            next_sample(s);
            check(s == first, "R9 constant output", s, first);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule